// File: doc/BRIEF.md
# Point-Multiplier Register Interface

This block is the bus-facing register file of an elliptic-curve point-multiplier coprocessor. Software sees 32-bit registers: two read-only identification words, a read-only version word, a control register whose start bit launches an operation, and a status register with a ready flag and a valid flag. Five operand buffers of twelve 32-bit words each hold the 384-bit scalar, the two input coordinates and the two result coordinates. The curve arithmetic is not part of the block.

Software fills the scalar and input buffers, then sets the start bit after having cleared it. Each 0-to-1 change produces exactly one start pulse to the engine. The engine reads operand words by buffer and word index, writes result words into the two output buffers, and raises done. The valid flag then tells software that the results can be read. The bus address is a word address: a register's byte offset is four times that address.

Top module: `ecpm_regif`

## Requirements
- R1: Reads return the constants 0x70746D75 at word address 0x000, 0x6C333834 at 0x001 (the ASCII core name "ptmul384"), and 0x302E3130 (ASCII "0.10") at 0x002. Writes to these addresses leave them unchanged.
- R2: The control register at 0x008 reads back the start bit in bit 1, and all other bits read as 0. The status register at 0x009 reads with bit 0 (ready) = 1, bit 1 = valid, and bits [31:2] = 0.
- R3: A write that changes control bit 1 from 0 to 1 while no operation runs drives eng_start_o high for exactly one cycle, which is the cycle after the write. Writing 1 again while the bit is already 1 gives no pulse. A 0-to-1 change made while an operation runs is dropped.
- R4: Valid is 0 after reset. Valid reads 0 from the cycle after the start pulse. Valid reads 1 from the cycle after eng_done_i is sampled high during a running operation.
- R5: Operand buffers lie at word addresses 0x080 (scalar), 0x090 (input X), 0x0A0 (input Y), 0x0B0 (output X) and 0x0C0 (output Y). In each buffer, word n is at base+n for n = 0..11, and word 0 holds bits [31:0]. On the engine read port, eng_rd_sel_i 0..4 selects the buffers in that order, and eng_rd_idx_i selects the word. The read is combinational.
- R6: The engine writes output X (eng_wr_sel_i = 0) or output Y (eng_wr_sel_i = 1) word eng_wr_idx_i when eng_wr_en_i is high. Bus writes to the output buffers are ignored.
- R7: Bus writes to the scalar and input buffers are ignored from the start-pulse cycle until done is accepted.
- R8: Reads of unmapped addresses (for example 0x003, 0x00A, 0x08C, 0x0D0) return 0, and writes to them change nothing.
- R9: After reset, all buffer words, the control register and bus_rdata_o read 0.
- R10: bus_rdata_o is loaded at the clock edge that samples a read request, and it holds its value in every cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 10 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| eng_start_o | output | 1 | One-cycle start pulse to the engine |
| eng_done_i | input | 1 | Engine completion |
| eng_rd_sel_i | input | 3 | Engine read buffer select |
| eng_rd_idx_i | input | 4 | Engine read word index |
| eng_rd_data_o | output | 32 | Engine read data |
| eng_wr_en_i | input | 1 | Engine result write enable |
| eng_wr_sel_i | input | 1 | 0 = output X, 1 = output Y |
| eng_wr_idx_i | input | 4 | Engine result word index |
| eng_wr_data_i | input | 32 | Engine result word |

## Verification
Bus read data is due one edge after the request. The bench drives each request at a falling edge and samples bus_rdata_o at the next falling edge. The start pulse must appear in the first cycle after the control write and be gone in the second, so the bench samples eng_start_o at both of those falling edges. Valid must be 0 one cycle after the pulse and 1 one cycle after done, and the bench reads status at those points. Engine read data is combinational, so it is checked a short delay after the select changes, within the same cycle.

// File: rtl/ecpm_pkg.sv
package ecpm_pkg;
  localparam int WORD_W   = 32;
  localparam int N_WORDS  = 12;
  localparam int N_OPS    = 5;
  localparam int IDX_W    = $clog2(N_WORDS);
  localparam int SEL_W    = $clog2(N_OPS);

  // word addresses
  localparam int A_ID0    = 'h000;
  localparam int A_ID1    = 'h001;
  localparam int A_VER    = 'h002;
  localparam int A_CTRL   = 'h008;
  localparam int A_STAT   = 'h009;
  localparam int A_OPBASE = 'h080;

  localparam logic [WORD_W-1:0] ID0_VAL = 32'h70746D75;
  localparam logic [WORD_W-1:0] ID1_VAL = 32'h6C333834;
  localparam logic [WORD_W-1:0] VER_VAL = 32'h302E3130;

  typedef enum logic [SEL_W-1:0] {
    OP_K  = 3'd0,
    OP_XI = 3'd1,
    OP_YI = 3'd2,
    OP_XO = 3'd3,
    OP_YO = 3'd4
  } op_e;

  localparam int CTRL_START_BIT = 1;
  localparam int STAT_READY_BIT = 0;
  localparam int STAT_VALID_BIT = 1;
endpackage

// File: rtl/ecpm_decode.sv
module ecpm_decode
  import ecpm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              id0_o,
  output logic              id1_o,
  output logic              ver_o,
  output logic              ctrl_o,
  output logic              stat_o,
  output logic [N_OPS-1:0]  op_hit_o,
  output logic [IDX_W-1:0]  word_o
);
  localparam int BLK_W    = ADDR_W - IDX_W;
  localparam int BASE_BLK = A_OPBASE >> IDX_W;

  logic [BLK_W-1:0] blk;
  assign blk    = addr_i[ADDR_W-1:IDX_W];
  assign word_o = addr_i[IDX_W-1:0];

  assign id0_o  = addr_i == ADDR_W'(A_ID0);
  assign id1_o  = addr_i == ADDR_W'(A_ID1);
  assign ver_o  = addr_i == ADDR_W'(A_VER);
  assign ctrl_o = addr_i == ADDR_W'(A_CTRL);
  assign stat_o = addr_i == ADDR_W'(A_STAT);

  for (genvar g = 0; g < N_OPS; g++) begin : g_hit
    assign op_hit_o[g] = (blk == BLK_W'(BASE_BLK + g)) &&
                         (word_o < IDX_W'(N_WORDS));
  end
endmodule

// File: rtl/ecpm_ctrl.sv
module ecpm_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_we_i,
  input  logic ctrl_bit_i,
  input  logic done_i,
  output logic ctrl_bit_o,
  output logic start_o,
  output logic busy_o,
  output logic valid_o
);
  logic ctrl_q, prev_q, busy_q, valid_q;

  // edge detect; an edge while busy is consumed without effect
  assign start_o = ctrl_q & ~prev_q & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= 1'b0;
      prev_q  <= 1'b0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_bit_i;
      prev_q <= ctrl_q;
      if (start_o) begin
        busy_q  <= 1'b1;
        valid_q <= 1'b0;
      end else if (busy_q && done_i) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
      end
    end
  end

  assign ctrl_bit_o = ctrl_q;
  assign busy_o     = busy_q;
  assign valid_o    = valid_q;
endmodule

// File: rtl/ecpm_opbuf.sv
module ecpm_opbuf #(
  parameter int N_WORDS = 12,
  parameter int WORD_W  = 32,
  parameter int IDX_W   = $clog2(N_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [IDX_W-1:0]  bus_idx_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  input  logic              eng_we_i,
  input  logic [IDX_W-1:0]  eng_wr_idx_i,
  input  logic [WORD_W-1:0] eng_wdata_i,
  input  logic [IDX_W-1:0]  eng_rd_idx_i,
  output logic [WORD_W-1:0] eng_rdata_o
);
  logic [WORD_W-1:0] mem_q [N_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_WORDS; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_WORDS; i++) begin
        if (eng_we_i && eng_wr_idx_i == IDX_W'(i))      mem_q[i] <= eng_wdata_i;
        else if (bus_we_i && bus_idx_i == IDX_W'(i))    mem_q[i] <= bus_wdata_i;
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    eng_rdata_o = '0;
    for (int i = 0; i < N_WORDS; i++) begin
      if (bus_idx_i == IDX_W'(i))    bus_rdata_o = mem_q[i];
      if (eng_rd_idx_i == IDX_W'(i)) eng_rdata_o = mem_q[i];
    end
  end
endmodule

// File: rtl/ecpm_regif.sv
module ecpm_regif
  import ecpm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              eng_start_o,
  input  logic              eng_done_i,
  input  logic [SEL_W-1:0]  eng_rd_sel_i,
  input  logic [IDX_W-1:0]  eng_rd_idx_i,
  output logic [WORD_W-1:0] eng_rd_data_o,
  input  logic              eng_wr_en_i,
  input  logic              eng_wr_sel_i,
  input  logic [IDX_W-1:0]  eng_wr_idx_i,
  input  logic [WORD_W-1:0] eng_wr_data_i
);
  logic             hit_id0, hit_id1, hit_ver, hit_ctrl, hit_stat;
  logic [N_OPS-1:0] op_hit;
  logic [IDX_W-1:0] word_idx;
  logic             wr_acc, rd_acc;
  logic             ctrl_bit, busy_w, valid_w, in_lock;
  logic [WORD_W-1:0] bus_rd_w [N_OPS];
  logic [WORD_W-1:0] eng_rd_w [N_OPS];
  logic [WORD_W-1:0] rd_mux, rdata_q;

  assign wr_acc = bus_req_i & bus_we_i;
  assign rd_acc = bus_req_i & ~bus_we_i;

  ecpm_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i   (bus_addr_i),
    .id0_o    (hit_id0),
    .id1_o    (hit_id1),
    .ver_o    (hit_ver),
    .ctrl_o   (hit_ctrl),
    .stat_o   (hit_stat),
    .op_hit_o (op_hit),
    .word_o   (word_idx)
  );

  ecpm_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (wr_acc & hit_ctrl),
    .ctrl_bit_i (bus_wdata_i[CTRL_START_BIT]),
    .done_i     (eng_done_i),
    .ctrl_bit_o (ctrl_bit),
    .start_o    (eng_start_o),
    .busy_o     (busy_w),
    .valid_o    (valid_w)
  );

  // inputs frozen from the start pulse until done is taken
  assign in_lock = busy_w | eng_start_o;

  for (genvar g = 0; g < N_OPS; g++) begin : g_buf
    logic bus_we, eng_we;
    if (g == int'(OP_XO) || g == int'(OP_YO)) begin : g_out
      assign bus_we = 1'b0;
      assign eng_we = eng_wr_en_i & (eng_wr_sel_i == (g == int'(OP_YO)));
    end else begin : g_in
      assign bus_we = wr_acc & op_hit[g] & ~in_lock;
      assign eng_we = 1'b0;
    end
    ecpm_opbuf #(.N_WORDS(N_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_buf (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .bus_we_i     (bus_we),
      .bus_idx_i    (word_idx),
      .bus_wdata_i  (bus_wdata_i),
      .bus_rdata_o  (bus_rd_w[g]),
      .eng_we_i     (eng_we),
      .eng_wr_idx_i (eng_wr_idx_i),
      .eng_wdata_i  (eng_wr_data_i),
      .eng_rd_idx_i (eng_rd_idx_i),
      .eng_rdata_o  (eng_rd_w[g])
    );
  end

  always_comb begin
    eng_rd_data_o = '0;
    for (int g = 0; g < N_OPS; g++)
      if (eng_rd_sel_i == SEL_W'(g)) eng_rd_data_o = eng_rd_w[g];
  end

  always_comb begin
    rd_mux = '0;
    if (hit_id0) rd_mux = ID0_VAL;
    if (hit_id1) rd_mux = ID1_VAL;
    if (hit_ver) rd_mux = VER_VAL;
    if (hit_ctrl) rd_mux[CTRL_START_BIT] = ctrl_bit;
    if (hit_stat) begin
      rd_mux[STAT_READY_BIT] = 1'b1;
      rd_mux[STAT_VALID_BIT] = valid_w;
    end
    for (int g = 0; g < N_OPS; g++)
      if (op_hit[g]) rd_mux = bus_rd_w[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_acc) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/ecpm_regif_chk.sv
module ecpm_regif_chk
  import ecpm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [WORD_W-1:0] bus_rdata_o,
  input logic              eng_start_o,
  input logic              eng_done_i,
  input logic              busy_i,
  input logic              valid_i
);
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o); // R3
  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> !busy_i); // R3
  AST_VALID_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> (!valid_i && busy_i)); // R4
  AST_VALID_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && eng_done_i) |=> (valid_i && !busy_i)); // R4
  AST_STATUS_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && bus_addr_i == ADDR_W'(A_STAT))
      |=> (bus_rdata_o[STAT_READY_BIT] && bus_rdata_o[WORD_W-1:2] == '0)); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && !bus_we_i) |=> $stable(bus_rdata_o)); // R10
endmodule

bind ecpm_regif ecpm_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .eng_start_o (eng_start_o),
  .eng_done_i  (eng_done_i),
  .busy_i      (busy_w),
  .valid_i     (valid_w)
);

// File: tb/ecpm_regif_tb.sv
module ecpm_regif_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [9:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        eng_start_o;
  logic        eng_done_i = 1'b0;
  logic [2:0]  eng_rd_sel_i = '0;
  logic [3:0]  eng_rd_idx_i = '0;
  logic [31:0] eng_rd_data_o;
  logic        eng_wr_en_i = 1'b0, eng_wr_sel_i = 1'b0;
  logic [3:0]  eng_wr_idx_i = '0;
  logic [31:0] eng_wr_data_i = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  ecpm_regif u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    bus_req_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    bus_req_i = 0; bus_we_i = 0;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
    bus_req_i = 1; bus_we_i = 0; bus_addr_i = a;
    @(posedge clk_i); @(negedge clk_i);
    bus_req_i = 0;
    d = bus_rdata_o;
  endtask

  task automatic expect_rd(input logic [9:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    bus_rd(a, d);
    check(d === exp, req, d, exp);
  endtask

  task automatic eng_fill();
    for (int i = 0; i < 12; i++) begin
      eng_wr_en_i = 1; eng_wr_sel_i = 0; eng_wr_idx_i = 4'(i); eng_wr_data_i = 32'hC0DE_0000 + i;
      @(negedge clk_i);
      eng_wr_sel_i = 1; eng_wr_data_i = 32'hD00D_0000 + i;
      @(negedge clk_i);
    end
    eng_wr_en_i = 0;
  endtask

  task automatic eng_done();
    eng_done_i = 1;
    @(negedge clk_i);
    eng_done_i = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(bus_rdata_o === 0, "R9 rdata", bus_rdata_o, 0);
    check(eng_start_o === 0, "R9 start", {31'b0, eng_start_o}, 0);
    expect_rd(10'h080, 0, "R9 scalar w0");
    expect_rd(10'h0CB, 0, "R9 outY w11");
    expect_rd(10'h008, 0, "R9 control");
    bus_rd(10'h009, d);
    check(d === 32'h1, "R4 valid at reset", d, 32'h1);
  endtask

  task automatic t_ident();
    expect_rd(10'h000, 32'h70746D75, "R1 id0");
    expect_rd(10'h001, 32'h6C333834, "R1 id1");
    expect_rd(10'h002, 32'h302E3130, "R1 version");
    bus_wr(10'h002, 32'hFFFF_FFFF);
    expect_rd(10'h002, 32'h302E3130, "R1 version write ignored");
  endtask

  task automatic t_ctrl_status();
    bus_wr(10'h008, 32'hFFFF_FFFD);
    expect_rd(10'h008, 0, "R2 control bit1 clear");
    expect_rd(10'h009, 32'h1, "R2 status ready");
  endtask

  task automatic t_operands();
    for (int i = 0; i < 12; i++) begin
      bus_wr(10'h080 + 10'(i), 32'hA000_0000 + i);
      bus_wr(10'h090 + 10'(i), 32'hB100_0000 + i);
      bus_wr(10'h0A0 + 10'(i), 32'hB200_0000 + i);
    end
    expect_rd(10'h080, 32'hA000_0000, "R5 scalar w0 bus");
    expect_rd(10'h0AB, 32'hB200_000B, "R5 inY w11 bus");
    eng_rd_sel_i = 0; eng_rd_idx_i = 0; #1;
    check(eng_rd_data_o === 32'hA000_0000, "R5 eng scalar w0", eng_rd_data_o, 32'hA000_0000);
    eng_rd_sel_i = 1; eng_rd_idx_i = 11; #1;
    check(eng_rd_data_o === 32'hB100_000B, "R5 eng inX w11", eng_rd_data_o, 32'hB100_000B);
    eng_rd_sel_i = 2; eng_rd_idx_i = 5; #1;
    check(eng_rd_data_o === 32'hB200_0005, "R5 eng inY w5", eng_rd_data_o, 32'hB200_0005);
    @(negedge clk_i);
  endtask

  task automatic t_unmapped();
    expect_rd(10'h003, 0, "R8 read 0x003");
    expect_rd(10'h00A, 0, "R8 read 0x00A");
    bus_wr(10'h08C, 32'h1234_5678);
    expect_rd(10'h08C, 0, "R8 read 0x08C");
    bus_wr(10'h0D0, 32'h1234_5678);
    expect_rd(10'h0D0, 0, "R8 read 0x0D0");
    expect_rd(10'h08B, 32'hA000_000B, "R8 neighbour untouched");
  endtask

  task automatic t_run();
    logic [31:0] d;
    bus_wr(10'h008, 32'h2);
    check(eng_start_o === 1, "R3 pulse after write", {31'b0, eng_start_o}, 1);
    @(negedge clk_i);
    check(eng_start_o === 0, "R3 pulse one cycle", {31'b0, eng_start_o}, 0);
    bus_rd(10'h009, d);
    check(d === 32'h1, "R4 valid cleared on start", d, 32'h1);
    bus_wr(10'h008, 32'h2);
    check(eng_start_o === 0, "R3 rewrite 1 no pulse", {31'b0, eng_start_o}, 0);
    bus_wr(10'h080, 32'hBAD0_BAD0);
    bus_wr(10'h095, 32'hBAD0_BAD0);
    eng_fill();
    eng_done();
    bus_rd(10'h009, d);
    check(d === 32'h3, "R4 valid set on done", d, 32'h3);
    expect_rd(10'h080, 32'hA000_0000, "R7 scalar locked");
    expect_rd(10'h095, 32'hB100_0005, "R7 inX locked");
    expect_rd(10'h0B0, 32'hC0DE_0000, "R6 outX w0");
    expect_rd(10'h0CB, 32'hD00D_000B, "R6 outY w11");
    eng_rd_sel_i = 3; eng_rd_idx_i = 7; #1;
    check(eng_rd_data_o === 32'hC0DE_0007, "R5 eng outX w7", eng_rd_data_o, 32'hC0DE_0007);
    @(negedge clk_i);
    bus_wr(10'h0B3, 32'hFFFF_0000);
    expect_rd(10'h0B3, 32'hC0DE_0003, "R6 outX bus write ignored");
    bus_wr(10'h080, 32'h5555_AAAA);
    expect_rd(10'h080, 32'h5555_AAAA, "R7 write accepted when idle");
  endtask

  task automatic t_rearm();
    bus_wr(10'h008, 32'h0);
    check(eng_start_o === 0, "R3 clear no pulse", {31'b0, eng_start_o}, 0);
    bus_wr(10'h008, 32'h2);
    check(eng_start_o === 1, "R3 second edge pulses", {31'b0, eng_start_o}, 1);
    @(negedge clk_i);
    bus_wr(10'h008, 32'h0);
    bus_wr(10'h008, 32'h2);
    check(eng_start_o === 0, "R3 edge while busy dropped", {31'b0, eng_start_o}, 0);
    eng_done();
    expect_rd(10'h009, 32'h3, "R4 valid after second run");
    expect_rd(10'h008, 32'h2, "R2 control reads start bit");
  endtask

  task automatic t_hold();
    logic [31:0] d;
    bus_rd(10'h001, d);
    repeat (3) @(negedge clk_i);
    check(bus_rdata_o === 32'h6C333834, "R10 rdata held", bus_rdata_o, 32'h6C333834);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_ident();
    t_ctrl_status();
    t_operands();
    t_unmapped();
    t_run();
    t_rearm();
    t_hold();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule